// File: doc/BRIEF.md
# Serial Receive Start and Clock Control

This block sits in front of the receive shift register of a synchronous serial port. It picks the bit clock for the receiver from one of three sources: an internally divided clock, the transmitter's bit clock, or an external clock pin. It can hold that clock off according to the level of the receive frame-sync line, and it chooses which edge of the clock samples incoming data. All of this runs on one system clock. The selected bit clock is treated as a level, and the block turns its edges into single-cycle sample and launch strobes.

On each sampling strobe the block tests a programmable start condition. The condition can be a frame-sync level, a frame-sync edge, a change of the sampled frame-sync value, a pulse on any synchronized edge, a transmit-start event, a continuous restart, or a match between recent data bits and a compare word. When the condition is met and the receiver is idle, the block sends a one-cycle start pulse to the shift register. It then ignores further start conditions until the shift register reports that the transfer has ended.

The block also decides whether the receive clock is driven onto the clock pin, and when. The external frame-sync, clock and data pins pass through two-stage synchronizers before any logic uses them.

Top module: `ssr_rx_start_ctrl`

## Requirements
- R1: `clk_sel` picks the bit clock. 0 selects `div_clk`, 1 selects `tx_clk` and 2 selects the synchronized `rx_clk_pin`. A rising edge on `tx_clk` or `div_clk` gives a strobe one cycle later, and one on the pin gives a strobe three cycles later. Code 3 gives no strobes and no clock output.
- R2: With `clk_inv`=1, `sample_en` pulses for one cycle after each rising edge of the selected clock and `launch_en` pulses after each falling edge. With `clk_inv`=0 the two are swapped. The two strobes are never high together.
- R3: `gate_sel` 0 lets every strobe through. 1 passes strobes only while the synchronized frame sync is low, and 2 only while it is high. Code 3 blocks all strobes.
- R4: `start_sel` 2 starts on a sampling strobe that sees frame sync low. `start_sel` 3 starts on one that sees it high.
- R5: `start_sel` 4 starts on a falling edge of the sampled frame sync, and 5 on a rising edge. An edge is found by comparing the value at the current sampling strobe with the value at the previous one. A steady level never starts.
- R6: `start_sel` 6 starts when the sampled frame sync differs between consecutive strobes. `start_sel` 7 starts at the next strobe after any edge of the synchronized input, so a pulse that falls entirely between two strobes still starts 7 but not 6.
- R7: `start_sel` 1 raises `start_pulse` in the cycle after `tx_start` is high, provided the receiver is enabled and idle.
- R8: `start_sel` 0 starts as soon as the receiver is enabled and idle. After a `xfer_done` pulse it starts again two cycles later.
- R9: `start_sel` 8 shifts the synchronized data pin into a history on each sampling strobe, with the newest bit in bit 0. It starts when the low `cmp_len` bits of the history equal the same bits of `cmp_word`. A `cmp_len` of 0 never matches.
- R10: `start_sel` codes 9 to 15 never start.
- R11: `start_pulse` lasts one cycle. From the pulse until `xfer_done`, the receiver is busy and start conditions are ignored. While `rx_en` is low, no start is issued and busy is cleared. After reset, all outputs are low.
- R12: `clk_out_mode` 0 and 3 keep `rx_clk_oe` and `rx_clk_out` low. Mode 1 drives the selected clock one cycle later, unaffected by `clk_inv` and gating. Mode 2 does the same, but only while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| clk_sel | input | 2 | Bit clock source select |
| start_sel | input | 4 | Start condition select |
| gate_sel | input | 2 | Frame-sync clock gating select |
| clk_inv | input | 1 | 1: sample on rising edge; 0: sample on falling edge |
| clk_out_mode | input | 2 | Clock pin drive mode |
| cmp_word | input | CMP_W | Compare word for the data-match start |
| cmp_len | input | LEN_W | Number of low bits compared |
| div_clk | input | 1 | Divided clock level, system-clock synchronous |
| tx_clk | input | 1 | Transmit bit clock level, system-clock synchronous |
| rx_clk_pin | input | 1 | External receive clock pin (asynchronous) |
| rx_fs_pin | input | 1 | Receive frame-sync pin (asynchronous) |
| rx_data_pin | input | 1 | Receive data pin (asynchronous) |
| tx_start | input | 1 | Transmitter start event |
| xfer_done | input | 1 | End of transfer from the shift register |
| start_pulse | output | 1 | One-cycle start to the shift register |
| sample_en | output | 1 | Data sampling strobe |
| launch_en | output | 1 | Opposite-edge strobe for output changes |
| rx_clk_out | output | 1 | Clock driven onto the pin |
| rx_clk_oe | output | 1 | Clock pin output enable |

## Verification
The strobes follow a rising or falling edge of a synchronous clock source by one cycle, and an edge on the clock pin by three cycles. `start_pulse` comes one cycle after `tx_start`, two cycles after `xfer_done` in continuous mode, and one cycle after the sampling strobe for the frame-sync and compare starts. The bench changes inputs just after a clock edge and checks the exact-latency results one tick later in exactly those cycles. Frame-sync starts are checked by counting `start_pulse` over a window of three bit-clock periods. Before each window, the frame-sync pin is given time to settle with the receiver disabled, so a count of one shows both that the start fired and that busy blocked any repeat.

// File: rtl/ssr_pkg.sv
// Shared codes for the serial receive start controller.
// Assumes: code values are fixed by the mode fields the block decodes.
package ssr_pkg;

    typedef enum logic [1:0] {
        CSRC_DIV  = 2'd0,
        CSRC_TX   = 2'd1,
        CSRC_PIN  = 2'd2,
        CSRC_NONE = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_LOW  = 2'd1,
        GATE_HIGH = 2'd2,
        GATE_NONE = 2'd3
    } gate_e;

    typedef enum logic [1:0] {
        CKO_OFF  = 2'd0,
        CKO_FREE = 2'd1,
        CKO_XFER = 2'd2,
        CKO_NONE = 2'd3
    } cko_e;

    typedef enum logic [3:0] {
        ST_CONT  = 4'd0,
        ST_TXGO  = 4'd1,
        ST_LOW   = 4'd2,
        ST_HIGH  = 4'd3,
        ST_FALL  = 4'd4,
        ST_RISE  = 4'd5,
        ST_CHG   = 4'd6,
        ST_ANY   = 4'd7,
        ST_MATCH = 4'd8
    } start_e;

endpackage

// File: rtl/ssr_sync.sv
// Multi-stage synchronizer for asynchronous pins.
// Assumes: each bit is independent; reset value is zero.
module ssr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift each pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ssr_clk_sel.sv
// Receive bit clock selection, frame-sync gating, edge strobes and pin drive.
// Assumes: div_clk and tx_clk are synchronous levels; pin and frame sync
// arrive already synchronized.
module ssr_clk_sel
    import ssr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic [1:0] gate_sel,
    input  logic       inv,
    input  logic [1:0] out_mode,
    input  logic       div_clk,
    input  logic       tx_clk,
    input  logic       pin_clk_s,
    input  logic       fs_s,
    input  logic       busy,
    output logic       sample_en,
    output logic       launch_en,
    output logic       clk_out,
    output logic       clk_oe
);

    logic sel_lvl, src_ok, gate_ok, drive_en;
    logic lvl_q, rise, fall;

    // Pick the bit clock level from the selected source.
    always_comb begin
        sel_lvl = 1'b0;
        src_ok  = 1'b1;
        case (clk_src_e'(src_sel))
            CSRC_DIV: sel_lvl = div_clk;
            CSRC_TX:  sel_lvl = tx_clk;
            CSRC_PIN: sel_lvl = pin_clk_s;
            default:  src_ok  = 1'b0;
        endcase
    end

    // Decide whether frame sync lets strobes through.
    always_comb begin
        case (gate_e'(gate_sel))
            GATE_OFF:  gate_ok = 1'b1;
            GATE_LOW:  gate_ok = ~fs_s;
            GATE_HIGH: gate_ok = fs_s;
            default:   gate_ok = 1'b0;
        endcase
    end

    // Decide whether the clock pin is driven in this cycle.
    always_comb begin
        case (cko_e'(out_mode))
            CKO_FREE: drive_en = 1'b1;
            CKO_XFER: drive_en = busy;
            default:  drive_en = 1'b0;
        endcase
    end

    assign rise   = sel_lvl & ~lvl_q;
    assign fall   = ~sel_lvl & lvl_q;
    assign clk_oe = (out_mode == CKO_FREE) || (out_mode == CKO_XFER);

    // Register the clock level, the strobes and the pin drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q     <= 1'b0;
            sample_en <= 1'b0;
            launch_en <= 1'b0;
            clk_out   <= 1'b0;
        end else begin
            lvl_q     <= sel_lvl;
            sample_en <= src_ok & gate_ok & (inv ? rise : fall);
            launch_en <= src_ok & gate_ok & (inv ? fall : rise);
            clk_out   <= src_ok & drive_en & sel_lvl;
        end
    end

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_en && launch_en));

    assert_src_none_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == CSRC_NONE) |=> (!sample_en && !launch_en && !clk_out));

    assert_gate_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_sel == GATE_HIGH && !fs_s) |=> !sample_en);

    assert_gate_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_sel == GATE_LOW && fs_s) |=> !sample_en);

    assert_cko_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == CKO_OFF || out_mode == CKO_NONE) |=> !clk_out);

    assert_cko_xfer_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == CKO_XFER && !busy) |=> !clk_out);

endmodule

// File: rtl/ssr_start_det.sv
// Start condition detection and transfer busy tracking.
// Assumes: sample_en is a one-cycle strobe; fs_s and data_s are synchronized.
module ssr_start_det
    import ssr_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int LEN_W = $clog2(CMP_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [3:0]       start_sel,
    input  logic             sample_en,
    input  logic             fs_s,
    input  logic             data_s,
    input  logic             tx_start,
    input  logic             xfer_done,
    input  logic [CMP_W-1:0] cmp_word,
    input  logic [LEN_W-1:0] cmp_len,
    output logic             start_pulse,
    output logic             busy
);

    logic             fs_smp, fs_d, edge_seen, raw_edge;
    logic [CMP_W-1:0] hist, hist_nxt, len_mask;
    logic             cmp_hit, trig, fire;

    assign raw_edge = fs_s ^ fs_d;
    assign hist_nxt = {hist[CMP_W-2:0], data_s};

    // Build the mask of compared history bits.
    for (genvar g = 0; g < CMP_W; g++) begin : g_mask
        assign len_mask[g] = (cmp_len > LEN_W'(g));
    end

    assign cmp_hit = (cmp_len != '0) && (((hist_nxt ^ cmp_word) & len_mask) == '0);

    // Evaluate the selected start condition for this cycle.
    always_comb begin
        case (start_e'(start_sel))
            ST_CONT:  trig = 1'b1;
            ST_TXGO:  trig = tx_start;
            ST_LOW:   trig = sample_en & ~fs_s;
            ST_HIGH:  trig = sample_en & fs_s;
            ST_FALL:  trig = sample_en & fs_smp & ~fs_s;
            ST_RISE:  trig = sample_en & ~fs_smp & fs_s;
            ST_CHG:   trig = sample_en & (fs_smp ^ fs_s);
            ST_ANY:   trig = sample_en & (edge_seen | raw_edge);
            ST_MATCH: trig = sample_en & cmp_hit;
            default:  trig = 1'b0;
        endcase
    end

    assign fire = trig & rx_en & ~busy;

    // Track sampled frame sync, pending raw edges and data history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_smp    <= 1'b0;
            fs_d      <= 1'b0;
            edge_seen <= 1'b0;
            hist      <= '0;
        end else begin
            fs_d <= fs_s;
            if (sample_en) begin
                fs_smp    <= fs_s;
                hist      <= hist_nxt;
                edge_seen <= 1'b0;
            end else if (raw_edge) begin
                edge_seen <= 1'b1;
            end
        end
    end

    // Issue the start pulse and hold busy until the transfer ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            busy        <= 1'b0;
        end else begin
            start_pulse <= fire;
            if (!rx_en)         busy <= 1'b0;
            else if (fire)      busy <= 1'b1;
            else if (xfer_done) busy <= 1'b0;
        end
    end

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_busy_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !start_pulse);

    assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !start_pulse);

    assert_code_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_sel > 4'd8) |=> !start_pulse);

    assert_tx_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_sel == ST_TXGO && tx_start && rx_en && !busy) |=> start_pulse);

    assert_cont_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_sel == ST_CONT && rx_en && !busy) |=> start_pulse);

endmodule

// File: rtl/ssr_rx_start_ctrl.sv
// Top of the serial receive start and clock controller.
// Assumes: one system clock; asynchronous pins are synchronized here.
module ssr_rx_start_ctrl
    import ssr_pkg::*;
#(
    parameter int CMP_W       = 16,
    parameter int LEN_W       = $clog2(CMP_W + 1),
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [1:0]       clk_sel,
    input  logic [3:0]       start_sel,
    input  logic [1:0]       gate_sel,
    input  logic             clk_inv,
    input  logic [1:0]       clk_out_mode,
    input  logic [CMP_W-1:0] cmp_word,
    input  logic [LEN_W-1:0] cmp_len,
    input  logic             div_clk,
    input  logic             tx_clk,
    input  logic             rx_clk_pin,
    input  logic             rx_fs_pin,
    input  logic             rx_data_pin,
    input  logic             tx_start,
    input  logic             xfer_done,
    output logic             start_pulse,
    output logic             sample_en,
    output logic             launch_en,
    output logic             rx_clk_out,
    output logic             rx_clk_oe
);

    localparam int NPIN = 3;

    logic [NPIN-1:0] pins_s;
    logic            busy;

    ssr_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rx_data_pin, rx_fs_pin, rx_clk_pin}),
        .q     (pins_s)
    );

    ssr_clk_sel u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (clk_sel),
        .gate_sel  (gate_sel),
        .inv       (clk_inv),
        .out_mode  (clk_out_mode),
        .div_clk   (div_clk),
        .tx_clk    (tx_clk),
        .pin_clk_s (pins_s[0]),
        .fs_s      (pins_s[1]),
        .busy      (busy),
        .sample_en (sample_en),
        .launch_en (launch_en),
        .clk_out   (rx_clk_out),
        .clk_oe    (rx_clk_oe)
    );

    ssr_start_det #(.CMP_W(CMP_W), .LEN_W(LEN_W)) u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .start_sel   (start_sel),
        .sample_en   (sample_en),
        .fs_s        (pins_s[1]),
        .data_s      (pins_s[2]),
        .tx_start    (tx_start),
        .xfer_done   (xfer_done),
        .cmp_word    (cmp_word),
        .cmp_len     (cmp_len),
        .start_pulse (start_pulse),
        .busy        (busy)
    );

endmodule

// File: tb/ssr_rx_start_ctrl_tb.sv
`timescale 1ns/1ps
module ssr_rx_start_ctrl_tb;

    localparam int CMP_W = 16;
    localparam int LEN_W = 5;
    localparam int NV    = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_en = 1'b0;
    logic [1:0]       clk_sel = 2'd0;
    logic [3:0]       start_sel = 4'd15;
    logic [1:0]       gate_sel = 2'd0;
    logic             clk_inv = 1'b1;
    logic [1:0]       clk_out_mode = 2'd0;
    logic [CMP_W-1:0] cmp_word = '0;
    logic [LEN_W-1:0] cmp_len = '0;
    logic             div_clk = 1'b0, tx_clk = 1'b0, rx_clk_pin = 1'b0;
    logic             rx_fs_pin = 1'b0, rx_data_pin = 1'b0;
    logic             tx_start = 1'b0, xfer_done = 1'b0;
    logic             start_pulse, sample_en, launch_en, rx_clk_out, rx_clk_oe;

    int n_chk = 0, n_fail = 0, pulses = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ssr_rx_start_ctrl #(.CMP_W(CMP_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .clk_sel(clk_sel),
        .start_sel(start_sel), .gate_sel(gate_sel), .clk_inv(clk_inv),
        .clk_out_mode(clk_out_mode), .cmp_word(cmp_word), .cmp_len(cmp_len),
        .div_clk(div_clk), .tx_clk(tx_clk), .rx_clk_pin(rx_clk_pin),
        .rx_fs_pin(rx_fs_pin), .rx_data_pin(rx_data_pin), .tx_start(tx_start),
        .xfer_done(xfer_done), .start_pulse(start_pulse), .sample_en(sample_en),
        .launch_en(launch_en), .rx_clk_out(rx_clk_out), .rx_clk_oe(rx_clk_oe)
    );

    // {start_sel, gate_sel, clk_inv, fs_before, fs_after, expected starts}
    localparam logic [10:0] VEC [NV] = '{
        {4'd2, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1},
        {4'd2, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0},
        {4'd3, 2'd0, 1'b1, 1'b0, 1'b1, 2'd1},
        {4'd3, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0},
        {4'd4, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1},
        {4'd4, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0},
        {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0},
        {4'd5, 2'd0, 1'b1, 1'b0, 1'b1, 2'd1},
        {4'd5, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0},
        {4'd5, 2'd0, 1'b1, 1'b1, 1'b1, 2'd0},
        {4'd5, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1},
        {4'd6, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1},
        {4'd6, 2'd0, 1'b1, 1'b0, 1'b1, 2'd1},
        {4'd6, 2'd0, 1'b1, 1'b1, 1'b1, 2'd0},
        {4'd7, 2'd0, 1'b1, 1'b0, 1'b1, 2'd1},
        {4'd7, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0},
        {4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1},
        {4'd1, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0},
        {4'd9, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0},
        {4'd15, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0},
        {4'd4, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0},
        {4'd3, 2'd2, 1'b1, 1'b0, 1'b1, 2'd1},
        {4'd2, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0},
        {4'd5, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (start_pulse) pulses++;
    endtask

    task automatic sclk_period();
        div_clk = 1'b1;
        repeat (4) tick();
        div_clk = 1'b0;
        repeat (4) tick();
    endtask

    task automatic sclk_bit(input logic b);
        rx_data_pin = b;
        sclk_period();
    endtask

    function automatic string req_of(input logic [3:0] ss, input logic [1:0] gt);
        if (gt != 2'd0) return "R3";
        case (ss)
            4'd0: return "R8";
            4'd1: return "R7";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            default: return "R10";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] ss;
        logic [1:0] gt, ex;
        logic iv, fb, fa;
        int cnt;

        repeat (3) tick();
        // R11: reset state of all outputs
        check("R11 reset start_pulse", int'(start_pulse), 0);
        check("R11 reset sample_en", int'(sample_en), 0);
        check("R12 reset clk_out", int'(rx_clk_out), 0);
        rst_n = 1'b1;
        tick();

        // Table of frame-sync start vectors
        for (int i = 0; i < NV; i++) begin
            {ss, gt, iv, fb, fa, ex} = VEC[i];
            rx_en = 1'b0; start_sel = ss; gate_sel = gt; clk_inv = iv;
            rx_fs_pin = fb;
            repeat (3) sclk_period();
            rx_fs_pin = fa;
            repeat (3) tick();
            rx_en = 1'b1;
            pulses = 0;
            repeat (3) sclk_period();
            check(req_of(ss, gt), pulses, int'(ex));
        end
        rx_en = 1'b0; gate_sel = 2'd0; start_sel = 4'd15; rx_fs_pin = 1'b0;
        repeat (4) tick();

        // R2: strobe edges for both polarities
        clk_inv = 1'b1; div_clk = 1'b1; tick();
        check("R2 inv1 rise sample", int'(sample_en), 1);
        check("R2 inv1 rise launch", int'(launch_en), 0);
        div_clk = 1'b0; tick();
        check("R2 inv1 fall launch", int'(launch_en), 1);
        check("R2 inv1 fall sample", int'(sample_en), 0);
        clk_inv = 1'b0; div_clk = 1'b1; tick();
        check("R2 inv0 rise launch", int'(launch_en), 1);
        check("R2 inv0 rise sample", int'(sample_en), 0);
        div_clk = 1'b0; tick();
        check("R2 inv0 fall sample", int'(sample_en), 1);
        clk_inv = 1'b1; repeat (2) tick();

        // R1: transmit clock, pin clock latency, reserved source
        clk_sel = 2'd1; tx_clk = 1'b1; tick();
        check("R1 tx clock strobe", int'(sample_en), 1);
        tx_clk = 1'b0; repeat (2) tick();
        clk_sel = 2'd2; repeat (3) tick();
        rx_clk_pin = 1'b1; tick(); tick();
        check("R1 pin clock not yet", int'(sample_en), 0);
        tick();
        check("R1 pin clock strobe", int'(sample_en), 1);
        rx_clk_pin = 1'b0; repeat (4) tick();
        clk_sel = 2'd3; clk_out_mode = 2'd1; cnt = 0;
        for (int k = 0; k < 16; k++) begin
            div_clk = k[2];
            tick();
            if (sample_en || launch_en || rx_clk_out) cnt++;
        end
        check("R1 reserved source silent", cnt, 0);
        clk_sel = 2'd0; clk_out_mode = 2'd0; div_clk = 1'b0; repeat (2) tick();

        // R3: gating on frame-sync low with frame sync high, then low
        gate_sel = 2'd1; rx_fs_pin = 1'b1; repeat (3) tick();
        cnt = 0;
        for (int k = 0; k < 16; k++) begin
            div_clk = k[2];
            tick();
            if (sample_en) cnt++;
        end
        check("R3 gated off strobes", cnt, 0);
        rx_fs_pin = 1'b0; repeat (3) tick(); cnt = 0;
        for (int k = 0; k < 16; k++) begin
            div_clk = k[2];
            tick();
            if (sample_en) cnt++;
        end
        check("R3 gated on strobes", cnt, 2);
        gate_sel = 2'd0; div_clk = 1'b0; repeat (2) tick();

        // R12: clock pin drive modes
        clk_out_mode = 2'd1; clk_inv = 1'b0; div_clk = 1'b1; tick();
        check("R12 free clock out inv0", int'(rx_clk_out), 1);
        check("R12 free oe", int'(rx_clk_oe), 1);
        div_clk = 1'b0; tick();
        check("R12 free clock low", int'(rx_clk_out), 0);
        clk_inv = 1'b1; div_clk = 1'b1; tick();
        check("R12 free clock out inv1", int'(rx_clk_out), 1);
        div_clk = 1'b0; clk_out_mode = 2'd0; tick();
        check("R12 off oe", int'(rx_clk_oe), 0);
        clk_out_mode = 2'd3; div_clk = 1'b1; tick();
        check("R12 reserved mode out", int'(rx_clk_out), 0);
        check("R12 reserved mode oe", int'(rx_clk_oe), 0);
        clk_out_mode = 2'd2; div_clk = 1'b0; tick(); div_clk = 1'b1; tick();
        check("R12 xfer mode idle", int'(rx_clk_out), 0);
        div_clk = 1'b0; tick();

        // R7: transmit start timing and busy blocking (R11)
        start_sel = 4'd1; rx_en = 1'b1; tick();
        tx_start = 1'b1; tick();
        tx_start = 1'b0;
        check("R7 start after tx_start", int'(start_pulse), 1);
        tick();
        check("R11 pulse is one cycle", int'(start_pulse), 0);
        div_clk = 1'b1; tick(); tick();
        check("R12 xfer mode busy drives", int'(rx_clk_out), 1);
        div_clk = 1'b0;
        pulses = 0; tx_start = 1'b1; tick(); tx_start = 1'b0; tick();
        check("R11 start ignored while busy", pulses, 0);
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        tx_start = 1'b1; tick(); tx_start = 1'b0;
        check("R7 start after transfer end", int'(start_pulse), 1);
        rx_en = 1'b0; clk_out_mode = 2'd0; repeat (2) tick();

        // R8: continuous restart two cycles after end of transfer
        start_sel = 4'd0; rx_en = 1'b1; repeat (3) tick();
        xfer_done = 1'b1; tick();
        xfer_done = 1'b0;
        check("R8 no restart first cycle", int'(start_pulse), 0);
        tick();
        check("R8 restart second cycle", int'(start_pulse), 1);
        rx_en = 1'b0; repeat (2) tick();

        // R9: data compare start with masking
        start_sel = 4'd8; clk_inv = 1'b0; cmp_len = 5'd4; cmp_word = 16'hA5AB;
        repeat (4) sclk_bit(1'b0);
        rx_en = 1'b1; pulses = 0;
        sclk_bit(1'b1); sclk_bit(1'b0); sclk_bit(1'b1);
        check("R9 partial pattern no start", pulses, 0);
        sclk_bit(1'b1);
        check("R9 pattern match start", pulses, 1);
        rx_en = 1'b0; cmp_len = 5'd0; repeat (2) tick();
        rx_en = 1'b1; pulses = 0;
        sclk_bit(1'b1); sclk_bit(1'b0); sclk_bit(1'b1); sclk_bit(1'b1);
        check("R9 zero length never matches", pulses, 0);
        rx_en = 1'b0; clk_inv = 1'b1; rx_data_pin = 1'b0; repeat (2) tick();

        // R6: narrow pulse between strobes, any-edge versus level change
        for (int m = 0; m < 2; m++) begin
            start_sel = (m == 0) ? 4'd7 : 4'd6;
            rx_en = 1'b0; rx_fs_pin = 1'b0;
            repeat (2) sclk_period();
            rx_fs_pin = 1'b1; repeat (3) tick();
            rx_fs_pin = 1'b0; repeat (4) tick();
            rx_en = 1'b1; pulses = 0;
            repeat (2) sclk_period();
            check((m == 0) ? "R6 any edge narrow pulse" : "R6 level change narrow pulse",
                  pulses, (m == 0) ? 1 : 0);
        end
        rx_en = 1'b0; tick();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule